// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block keeps the return addresses of a small microcontroller core with a 12-bit program counter. A subroutine call pushes the current program counter into a private six-level store, and a return pops the most recent address back out. The storage and its level pointer are reachable only through the push and pop strobes. No data or program address maps onto them.

The block also controls interrupt acknowledgement. An interrupt request is latched as pending. The acknowledge happens in a cycle with no call or return strobe, and only while a free level exists. In that cycle the block pushes the program counter on the core's behalf and clears the pending flag. While the stack is full, a pending request is held back. It is serviced in the first quiet cycle after a return frees a level. A call on a full stack still pushes, and the oldest saved address is dropped.

Top module: `ret_stack`

## Requirements
- R1: After reset the stack is empty (`empty_o`=1, `full_o`=0), with `irq_pend_o`, `irq_ack_o` and `underflow_o` all 0.
- R2: A push stores `pc_i` on top. While `pop_i` is high on a non-empty stack, `pc_o` shows the top entry, and the pop removes it, so values come back in reverse order of pushing.
- R3: The stack holds six levels. `full_o` is 1 exactly when six entries are held, and `empty_o` is 1 exactly when none are held.
- R4: A push on a full stack keeps it full, stores the new value on top and discards the oldest entry.
- R5: A pop on an empty stack leaves it empty and drives `pc_o` to 0. `underflow_o` is 1 in the cycle after such a pop, and 0 after any other cycle.
- R6: If `push_i` and `pop_i` are both 1 in a cycle, only the pop takes effect and the push is ignored.
- R7: `irq_i` high in a cycle sets `irq_pend_o` in the next cycle. The flag stays set until an acknowledge clears it.
- R8: `irq_ack_o` is 1 in a cycle exactly when `irq_pend_o` is 1, the stack is not full, and neither strobe is asserted. That cycle pushes `pc_i`, and the pending flag is clear afterwards unless `irq_i` was also high.
- R9: A request pending on a full stack is not acknowledged. It is acknowledged in the first strobe-free cycle after a pop has freed a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Call strobe: save `pc_i` |
| pop_i | input | 1 | Return strobe: remove top entry |
| pc_i | input | 12 | Program counter to save |
| irq_i | input | 1 | Unmasked interrupt request |
| pc_o | output | 12 | Top entry (0 when empty) |
| full_o | output | 1 | Six levels in use |
| empty_o | output | 1 | No level in use |
| irq_pend_o | output | 1 | Interrupt request latched |
| irq_ack_o | output | 1 | Interrupt acknowledged this cycle |
| underflow_o | output | 1 | Previous cycle popped an empty stack |

## Verification
On every cycle, the embedded properties check the level bounds, the one-level step of a push or pop, and the saturation on a push to a full stack. They also check the underflow pulse, pop priority over push, the latching of requests, and that no acknowledge is given while full. The data paths can be judged only by the bench scenarios. These include the reverse-order return of stored addresses, the loss of exactly the oldest entry after a call on a full stack, and which address an acknowledge saved. Sweeps over every fill level from zero to past full cover these.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 6,
  parameter int PC_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            irq_i,
  output logic [PC_W-1:0] pc_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            irq_pend_o,
  output logic            irq_ack_o,
  output logic            underflow_o
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  lvl_q [DEPTH];
  logic [LVL_W-1:0] used_q;
  logic             pend_q, und_q;
  logic             do_pop, do_push;

  assign empty_o     = (used_q == '0);
  assign full_o      = (used_q == LVL_W'(DEPTH));
  assign irq_pend_o  = pend_q;
  assign underflow_o = und_q;
  assign irq_ack_o   = pend_q && !push_i && !pop_i && !full_o;
  assign do_pop      = pop_i;
  assign do_push     = (push_i && !pop_i) || irq_ack_o;
  assign pc_o        = empty_o ? '0 : lvl_q[used_q - LVL_W'(1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      pend_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      und_q  <= do_pop && empty_o;
      pend_q <= irq_i || (pend_q && !irq_ack_o);
      if (do_pop) begin
        if (!empty_o) used_q <= used_q - LVL_W'(1);
      end else if (do_push && !full_o) begin
        used_q <= used_q + LVL_W'(1);
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (do_push && !do_pop) begin
        if (full_o) begin
          if (g == DEPTH - 1) lvl_q[g] <= pc_i;
          else                lvl_q[g] <= lvl_q[(g + 1) % DEPTH];
        end else if (used_q == LVL_W'(g)) begin
          lvl_q[g] <= pc_i;
        end
      end
    end
  end

  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= LVL_W'(DEPTH));
  a_r3_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  a_r2_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !empty_o |=> used_q == $past(used_q) - LVL_W'(1));
  a_r4_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i && full_o |=> full_o);
  a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && empty_o |=> underflow_o && empty_o);
  a_r5_no_false_und: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && empty_o) |=> !underflow_o);
  a_r6_pop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !empty_o |=> used_q == $past(used_q) - LVL_W'(1));
  a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> irq_pend_o);
  a_r9_no_ack_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);
  a_r8_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |=> used_q == $past(used_q) + LVL_W'(1));
endmodule

// File: tb/test_ret_stack.sv
module test_ret_stack;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, irq_i = 0;
  logic [11:0] pc_i = '0;
  logic [11:0] pc_o;
  logic full_o, empty_o, irq_pend_o, irq_ack_o, underflow_o;
  int n_cmp = 0, n_bad = 0;
  logic [11:0] mdl[$];
  logic m_pend = 0, m_und = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ret_stack i_ret_stack (.clk, .rst_n, .push_i, .pop_i, .pc_i, .irq_i,
    .pc_o, .full_o, .empty_o, .irq_pend_o, .irq_ack_o, .underflow_o);

  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_state();
    chk("R3 empty", int'(empty_o), int'(mdl.size() == 0));
    chk("R3/R4 full", int'(full_o), int'(mdl.size() == 6));
    chk("R7 pending", int'(irq_pend_o), int'(m_pend));
    chk("R5 underflow", int'(underflow_o), int'(m_und));
  endtask

  // inputs applied just after a falling edge; checks before the rising edge
  task automatic step(bit pu, bit po, bit iq, logic [11:0] pc);
    bit ack;
    push_i = pu; pop_i = po; irq_i = iq; pc_i = pc;
    #1;
    chk_state();
    ack = m_pend && !pu && !po && mdl.size() < 6;
    chk("R8/R9 ack", int'(irq_ack_o), int'(ack));
    if (po) chk("R2/R5 pc_o", int'(pc_o), mdl.size() ? int'(mdl[$]) : 0);
    m_und = po && mdl.size() == 0;
    if (po) begin
      if (mdl.size()) void'(mdl.pop_back());
    end else if (pu || ack) begin
      if (mdl.size() == 6) void'(mdl.pop_front());
      mdl.push_back(pc);
    end
    m_pend = iq || (m_pend && !ack);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 pend", int'(irq_pend_o), 0);
    chk("R1 ack", int'(irq_ack_o), 0);
    chk("R1 und", int'(underflow_o), 0);
    @(negedge clk);
    // R2 R3 R4 R5: sweep fill levels 0..8, drain one past empty
    for (int n = 0; n <= 8; n++) begin
      for (int k = 0; k < n; k++) step(1, 0, 0, 12'(n * 256 + k * 37 + 1));
      for (int k = 0; k <= (n > 6 ? 6 : n); k++) step(0, 1, 0, 0);
      step(0, 0, 0, 0);
    end
    // R6: both strobes at every level
    for (int n = 0; n <= 6; n++) begin
      for (int k = 0; k < n; k++) step(1, 0, 0, 12'(3000 + k));
      step(1, 1, 0, 12'hABC);
      while (mdl.size()) step(0, 1, 0, 0);
      step(0, 0, 0, 0);
    end
    // R7 R8: request on a partly filled stack, acknowledged when quiet
    step(1, 0, 0, 12'h111);
    step(0, 0, 1, 12'h222);
    step(1, 0, 0, 12'h333);
    step(0, 0, 0, 12'h444);
    step(0, 0, 1, 12'h555);
    step(0, 0, 0, 12'h666);
    while (mdl.size()) step(0, 1, 0, 0);
    // R9: request withheld while full, served after a pop
    for (int k = 0; k < 6; k++) step(1, 0, 0, 12'(100 + k));
    step(0, 0, 1, 12'h7AA);
    step(0, 0, 0, 12'h7AB);
    step(1, 0, 0, 12'h7AC);
    step(0, 1, 0, 0);
    step(0, 0, 0, 12'h7AD);
    step(0, 0, 0, 12'h7AE);
    while (mdl.size()) step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule